// File: doc/BRIEF.md
# LCD Panel Power-Up Sequencer

This block brings a small TFT panel controller out of reset by replaying a fixed list of register settings over a 16-bit parallel write-only bus of the 8080 kind. After a start pulse it walks a built-in table of 60 entries. For each entry it performs two bus writes. The first is an index write with the select line low, carrying the register number. The second is a data write with the select line high, carrying the value. Both bytes sit on the low half of the data bus, and the upper byte is zero.

Some entries are followed by a pause that stages the panel's power-up. Register 0x1F is written four times in a row, and each of those writes waits about 5 ms. The first display-on write is followed by about 40 ms before the second one. All pauses are cycle counts derived from the `CLK_HZ` parameter, so a bench can shrink them. The list ends by setting a full-screen drawing window. When the last write is complete, the block raises `done` and keeps it high until the next start.

Top module: `lcd_init_seq`

## Requirements
- R1: While `rstN` is low and after its release with no start, `lcdCsN`=1, `lcdWrN`=1, `busy`=0 and `done`=0.
- R2: Every entry produces exactly two writes: an index write with `lcdRs`=0, then a data write with `lcdRs`=1. The byte is placed on `lcdData[7:0]` and `lcdData[15:8]`=0. There are 120 writes per run.
- R3: The (index, value) pairs appear in the fixed table order. This order includes a gamma block over 0x40..0x4C and 0x50..0x5D, running from 0x40=0x00 to 0x5D=0xCC. The frame-rate write 0x18=0x36 comes before the oscillator enable 0x19=0x01. The pixel format 0x17=0x05 comes before the display-on writes.
- R4: Register 0x1F is written with 0x88, 0x80, 0x90 and 0xD0 in that order. After each of these writes, the next write's rising `lcdWrN` comes at least CLK_HZ/200 cycles after that write's rising `lcdWrN`.
- R5: 0x28=0x38 is followed by at least CLK_HZ/25 cycles, measured between rising `lcdWrN` edges, before the index write of 0x28=0x3C.
- R6: Each write holds `lcdWrN` low for exactly `WR_LOW` cycles. `lcdCsN` is low throughout the write. `lcdRs` and `lcdData` are stable while `lcdWrN` is low and at its rising edge.
- R7: `busy` is high from the cycle after start is sampled. It stays high for exactly the sum over entries of 2*(WR_LOW+2) cycles plus each entry's pause. `busy` and `done` are never high together.
- R8: `done` rises in the cycle after `busy` falls and stays high until a start is sampled. A start pulse while `busy` is high has no effect on the writes or on the busy length.
- R9: A start sampled while `done` is high replays the whole sequence from the first entry.
- R10: The last eight entries are registers 0x02..0x09 with values 0x00,0x00,0x00,0xEF,0x00,0x00,0x01,0x3F. These set the column window to 0x0000..0x00EF and the row window to 0x0000..0x013F, with the MSB register before the LSB register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run the sequence |
| lcdCsN | output | 1 | Panel chip select, active low |
| lcdRs | output | 1 | Register select: 0 index, 1 data |
| lcdWrN | output | 1 | Write strobe, active low, latched on rising edge |
| lcdData | output | 16 | Parallel write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete, held until next start |

## Verification
The assertions take for granted that `start` is a single-cycle pulse, and that `WR_LOW` and the derived pauses are at least one cycle. The stimulus keeps to this. It pulses `start` for one cycle only, and it chooses a `CLK_HZ` value small enough for the pauses to be short but far longer than one cycle. One pulse is placed deliberately in the middle of a run, so that the check that it is ignored sees a stimulus that is legal but unwanted. The bench's model is armed only by a start seen while it believes the block is idle or finished.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;
  localparam int NUM_STEPS = 60;

  localparam logic [1:0] DLY_NONE  = 2'd0;
  localparam logic [1:0] DLY_SHORT = 2'd1;
  localparam logic [1:0] DLY_LONG  = 2'd2;

  typedef struct packed {
    logic clrStep;
    logic advStep;
    logic setData;
    logic clrData;
    logic loadWr;
    logic loadDly;
    logic dec;
  } strobe_t;
endpackage

// File: rtl/lcdseq_rom.sv
module lcdseq_rom
  import lcdseq_pkg::*;
#(
  parameter int STEP_W = 6
) (
  input  logic [STEP_W-1:0] step,
  output logic [7:0]        regIdx,
  output logic [7:0]        regVal,
  output logic [1:0]        dlyKind,
  output logic              isLast
);
  logic [17:0] ent;

  always_comb begin
    case (int'(step))
      0:  ent = {DLY_NONE, 8'hEA, 8'h00};
      1:  ent = {DLY_NONE, 8'hEB, 8'h20};
      2:  ent = {DLY_NONE, 8'hEC, 8'h0F};
      3:  ent = {DLY_NONE, 8'hED, 8'hC4};
      4:  ent = {DLY_NONE, 8'hE8, 8'hC4};
      5:  ent = {DLY_NONE, 8'hE9, 8'hC4};
      6:  ent = {DLY_NONE, 8'hF1, 8'hC4};
      7:  ent = {DLY_NONE, 8'hF2, 8'hC4};
      8:  ent = {DLY_NONE, 8'h27, 8'hC4};
      9:  ent = {DLY_NONE, 8'h40, 8'h00};
      10: ent = {DLY_NONE, 8'h41, 8'h00};
      11: ent = {DLY_NONE, 8'h42, 8'h01};
      12: ent = {DLY_NONE, 8'h43, 8'h13};
      13: ent = {DLY_NONE, 8'h44, 8'h10};
      14: ent = {DLY_NONE, 8'h45, 8'h26};
      15: ent = {DLY_NONE, 8'h46, 8'h08};
      16: ent = {DLY_NONE, 8'h47, 8'h81};
      17: ent = {DLY_NONE, 8'h48, 8'h02};
      18: ent = {DLY_NONE, 8'h49, 8'h12};
      19: ent = {DLY_NONE, 8'h4A, 8'h18};
      20: ent = {DLY_NONE, 8'h4B, 8'h19};
      21: ent = {DLY_NONE, 8'h4C, 8'h14};
      22: ent = {DLY_NONE, 8'h50, 8'h19};
      23: ent = {DLY_NONE, 8'h51, 8'h2F};
      24: ent = {DLY_NONE, 8'h52, 8'h2C};
      25: ent = {DLY_NONE, 8'h53, 8'h3E};
      26: ent = {DLY_NONE, 8'h54, 8'h3F};
      27: ent = {DLY_NONE, 8'h55, 8'h3F};
      28: ent = {DLY_NONE, 8'h56, 8'h3E};
      29: ent = {DLY_NONE, 8'h57, 8'h77};
      30: ent = {DLY_NONE, 8'h58, 8'h0B};
      31: ent = {DLY_NONE, 8'h59, 8'h06};
      32: ent = {DLY_NONE, 8'h5A, 8'h07};
      33: ent = {DLY_NONE, 8'h5B, 8'h0D};
      34: ent = {DLY_NONE, 8'h5C, 8'h1D};
      35: ent = {DLY_NONE, 8'h5D, 8'hCC};
      36: ent = {DLY_NONE, 8'h1B, 8'h1B};
      37: ent = {DLY_NONE, 8'h1A, 8'h01};
      38: ent = {DLY_NONE, 8'h24, 8'h2F};
      39: ent = {DLY_NONE, 8'h25, 8'h57};
      40: ent = {DLY_NONE, 8'h23, 8'h86};
      41: ent = {DLY_NONE, 8'h18, 8'h36};
      42: ent = {DLY_NONE, 8'h19, 8'h01};
      43: ent = {DLY_NONE, 8'h01, 8'h00};
      44: ent = {DLY_SHORT, 8'h1F, 8'h88};
      45: ent = {DLY_SHORT, 8'h1F, 8'h80};
      46: ent = {DLY_SHORT, 8'h1F, 8'h90};
      47: ent = {DLY_SHORT, 8'h1F, 8'hD0};
      48: ent = {DLY_NONE, 8'h17, 8'h05};
      49: ent = {DLY_NONE, 8'h36, 8'h00};
      50: ent = {DLY_LONG, 8'h28, 8'h38};
      51: ent = {DLY_NONE, 8'h28, 8'h3C};
      52: ent = {DLY_NONE, 8'h02, 8'h00};
      53: ent = {DLY_NONE, 8'h03, 8'h00};
      54: ent = {DLY_NONE, 8'h04, 8'h00};
      55: ent = {DLY_NONE, 8'h05, 8'hEF};
      56: ent = {DLY_NONE, 8'h06, 8'h00};
      57: ent = {DLY_NONE, 8'h07, 8'h00};
      58: ent = {DLY_NONE, 8'h08, 8'h01};
      59: ent = {DLY_NONE, 8'h09, 8'h3F};
      default: ent = '0;
    endcase
  end

  assign dlyKind = ent[17:16];
  assign regIdx  = ent[15:8];
  assign regVal  = ent[7:0];
  assign isLast  = (step == STEP_W'(NUM_STEPS - 1));
endmodule

// File: rtl/lcdseq_dpath.sv
module lcdseq_dpath
  import lcdseq_pkg::*;
#(
  parameter int STEP_W    = 6,
  parameter int CNT_W     = 8,
  parameter int WR_LOW    = 3,
  parameter int SHORT_CYC = 10,
  parameter int LONG_CYC  = 80
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     stb,
  output logic        dataPhase,
  output logic        cntZero,
  output logic        hasDly,
  output logic        isLast,
  output logic [15:0] busData
);
  logic [STEP_W-1:0] step;
  logic [CNT_W-1:0]  cnt;
  logic [7:0]        regIdx, regVal;
  logic [1:0]        dlyKind;

  lcdseq_rom #(.STEP_W(STEP_W)) rom_i (
    .step(step), .regIdx(regIdx), .regVal(regVal),
    .dlyKind(dlyKind), .isLast(isLast)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step      <= '0;
      dataPhase <= 1'b0;
      cnt       <= '0;
    end else begin
      if (stb.clrStep)      step <= '0;
      else if (stb.advStep) step <= step + 1'b1;
      if (stb.clrData)      dataPhase <= 1'b0;
      else if (stb.setData) dataPhase <= 1'b1;
      if (stb.loadWr)
        cnt <= CNT_W'(WR_LOW - 1);
      else if (stb.loadDly)
        cnt <= (dlyKind == DLY_LONG) ? CNT_W'(LONG_CYC - 1) : CNT_W'(SHORT_CYC - 1);
      else if (stb.dec)
        cnt <= cnt - 1'b1;
    end
  end

  assign cntZero = (cnt == '0);
  assign hasDly  = (dlyKind != DLY_NONE);
  assign busData = {8'h00, dataPhase ? regVal : regIdx};
endmodule

// File: rtl/lcdseq_ctrl.sv
module lcdseq_ctrl
  import lcdseq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    dataPhase,
  input  logic    cntZero,
  input  logic    hasDly,
  input  logic    isLast,
  output strobe_t stb,
  output logic    csN,
  output logic    wrN,
  output logic    busy,
  output logic    done
);
  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOW, S_HIGH, S_WAIT, S_DONE} state_e;
  state_e st, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) st <= S_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    nxt = st;
    stb = '0;
    case (st)
      S_IDLE, S_DONE: if (start) begin
        stb.clrStep = 1'b1;
        stb.clrData = 1'b1;
        nxt = S_SETUP;
      end
      S_SETUP: begin
        stb.loadWr = 1'b1;
        nxt = S_LOW;
      end
      S_LOW: begin
        if (cntZero) nxt = S_HIGH;
        else         stb.dec = 1'b1;
      end
      S_HIGH: begin
        if (!dataPhase) begin
          stb.setData = 1'b1;
          nxt = S_SETUP;
        end else if (hasDly) begin
          stb.loadDly = 1'b1;
          nxt = S_WAIT;
        end else if (isLast) begin
          nxt = S_DONE;
        end else begin
          stb.advStep = 1'b1;
          stb.clrData = 1'b1;
          nxt = S_SETUP;
        end
      end
      S_WAIT: begin
        if (!cntZero) begin
          stb.dec = 1'b1;
        end else if (isLast) begin
          nxt = S_DONE;
        end else begin
          stb.advStep = 1'b1;
          stb.clrData = 1'b1;
          nxt = S_SETUP;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign csN  = (st == S_IDLE) || (st == S_WAIT) || (st == S_DONE);
  assign wrN  = (st != S_LOW);
  assign busy = (st != S_IDLE) && (st != S_DONE);
  assign done = (st == S_DONE);
endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcdseq_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int WR_LOW = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output logic        lcdCsN,
  output logic        lcdRs,
  output logic        lcdWrN,
  output logic [15:0] lcdData,
  output logic        busy,
  output logic        done
);
  localparam int SHORT_CYC = CLK_HZ / 200;
  localparam int LONG_CYC  = CLK_HZ / 25;
  localparam int CNT_MAX   = (LONG_CYC > WR_LOW) ? LONG_CYC : WR_LOW;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam int STEP_W    = $clog2(NUM_STEPS);

  strobe_t stb;
  logic    dataPhase, cntZero, hasDly, isLast;

  lcdseq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start),
    .dataPhase(dataPhase), .cntZero(cntZero), .hasDly(hasDly), .isLast(isLast),
    .stb(stb), .csN(lcdCsN), .wrN(lcdWrN), .busy(busy), .done(done)
  );

  lcdseq_dpath #(
    .STEP_W(STEP_W), .CNT_W(CNT_W), .WR_LOW(WR_LOW),
    .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .dataPhase(dataPhase), .cntZero(cntZero), .hasDly(hasDly),
    .isLast(isLast), .busData(lcdData)
  );

  assign lcdRs = dataPhase;
endmodule

// File: rtl/lcd_init_seq_chk.sv
module lcd_init_seq_chk #(
  parameter int WR_LOW = 3
) (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        lcdCsN,
  input logic        lcdRs,
  input logic        lcdWrN,
  input logic [15:0] lcdData,
  input logic        busy,
  input logic        done
);
  int lowCnt;

  always_ff @(posedge clk) begin
    if (!rstN)       lowCnt <= 0;
    else if (!lcdWrN) lowCnt <= lowCnt + 1;
    else             lowCnt <= 0;
  end

  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (lcdCsN && lcdWrN));

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    !lcdWrN |-> (lcdData[15:8] == 8'h00));

  assert_cs_during_wr_R6: assert property (@(posedge clk) disable iff (!rstN)
    !lcdWrN |-> !lcdCsN);

  assert_bus_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!lcdWrN && !$past(lcdWrN)) |-> ($stable(lcdData) && $stable(lcdRs)));

  assert_stable_at_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lcdWrN) |-> ($stable(lcdData) && $stable(lcdRs)));

  assert_wr_width_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lcdWrN) |-> (lowCnt == WR_LOW));

  assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  assert_done_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy));
endmodule

bind lcd_init_seq lcd_init_seq_chk #(.WR_LOW(WR_LOW)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .lcdCsN(lcdCsN), .lcdRs(lcdRs),
  .lcdWrN(lcdWrN), .lcdData(lcdData), .busy(busy), .done(done)
);

// File: tb/lcd_init_seq_tb_top.sv
`timescale 1ns/1ps
module lcd_init_seq_tb_top;
  localparam int CLK_HZ  = 200_000;
  localparam int WR_LOW  = 2;
  localparam int SHORT_C = CLK_HZ / 200;
  localparam int LONG_C  = CLK_HZ / 25;
  localparam int NENT    = 60;
  localparam int NWR     = 2 * NENT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic lcdCsN, lcdRs, lcdWrN, busy, done;
  logic [15:0] lcdData;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lcd_init_seq #(.CLK_HZ(CLK_HZ), .WR_LOW(WR_LOW)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .lcdCsN(lcdCsN), .lcdRs(lcdRs),
    .lcdWrN(lcdWrN), .lcdData(lcdData), .busy(busy), .done(done)
  );

  function automatic logic [15:0] expWord(input int k);
    logic [15:0] w [NENT] = '{
      16'hEA00, 16'hEB20, 16'hEC0F, 16'hEDC4, 16'hE8C4, 16'hE9C4, 16'hF1C4, 16'hF2C4,
      16'h27C4, 16'h4000, 16'h4100, 16'h4201, 16'h4313, 16'h4410, 16'h4526, 16'h4608,
      16'h4781, 16'h4802, 16'h4912, 16'h4A18, 16'h4B19, 16'h4C14, 16'h5019, 16'h512F,
      16'h522C, 16'h533E, 16'h543F, 16'h553F, 16'h563E, 16'h5777, 16'h580B, 16'h5906,
      16'h5A07, 16'h5B0D, 16'h5C1D, 16'h5DCC, 16'h1B1B, 16'h1A01, 16'h242F, 16'h2557,
      16'h2386, 16'h1836, 16'h1901, 16'h0100, 16'h1F88, 16'h1F80, 16'h1F90, 16'h1FD0,
      16'h1705, 16'h3600, 16'h2838, 16'h283C, 16'h0200, 16'h0300, 16'h0400, 16'h05EF,
      16'h0600, 16'h0700, 16'h0801, 16'h093F};
    return w[k];
  endfunction

  function automatic int expDelay(input int k);
    logic [15:0] w = expWord(k);
    if (w[15:8] == 8'h1F) return SHORT_C;
    if (w == 16'h2838)    return LONG_C;
    return 0;
  endfunction

  function automatic int runCycles();
    int s = 0;
    for (int k = 0; k < NENT; k++) s += 2 * (WR_LOW + 2) + expDelay(k);
    return s;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // reference model: busy/done expectation and write capture, sampled on negedge
  int left = 0;
  bit armed = 0;
  bit expDone = 0;
  int cyc = 0;
  int capIdx = 0;
  int lastRise = 0;
  int lowRun = 0;
  logic prevWr = 1'b1;

  always @(posedge clk) armed = rstN && start && (left == 0);

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (armed) begin
        left = runCycles();
        expDone = 0;
      end
      chk(busy == (left > 0), "R7 busy per cycle", busy, left > 0);
      chk(done == expDone, "R8 done per cycle", done, expDone);
      if (left > 0) begin
        left--;
        if (left == 0) expDone = 1;
      end
      if (!lcdWrN) lowRun++;
      if (prevWr == 1'b0 && lcdWrN == 1'b1) begin
        int w, k, ph;
        logic [15:0] ew;
        w  = capIdx % NWR;
        k  = w / 2;
        ph = w % 2;
        ew = expWord(k);
        chk(lcdRs == ph[0], "R2 rs phase", lcdRs, ph);
        chk(lcdData[15:8] == 8'h00, "R2 upper byte", lcdData[15:8], 0);
        chk(lcdData[7:0] == (ph ? ew[7:0] : ew[15:8]), (k >= 52) ? "R10 window" : "R3 pair",
            lcdData[7:0], ph ? ew[7:0] : ew[15:8]);
        chk(lowRun == WR_LOW, "R6 wr low width", lowRun, WR_LOW);
        if (ph == 0 && k > 0 && expDelay(k - 1) > 0)
          chk(cyc - lastRise >= expDelay(k - 1), (expDelay(k - 1) == LONG_C) ? "R5 long gap" : "R4 short gap",
              cyc - lastRise, expDelay(k - 1));
        lastRise = cyc;
        capIdx++;
      end
      if (lcdWrN) lowRun = 0;
      prevWr = lcdWrN;
    end
  end

  task automatic pulseStart();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk({lcdCsN, lcdWrN, busy, done} == 4'b1100, "R1 in reset", {lcdCsN, lcdWrN, busy, done}, 4'b1100);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk({lcdCsN, lcdWrN, busy, done} == 4'b1100, "R1 idle after reset", {lcdCsN, lcdWrN, busy, done}, 4'b1100);
    chk(capIdx == 0, "R1 no writes", capIdx, 0);

    pulseStart();
    waitDone();
    chk(capIdx == NWR, "R2 write count run1", capIdx, NWR);
    repeat (200) @(negedge clk);
    chk(done == 1'b1, "R8 done held", done, 1);
    chk(capIdx == NWR, "R8 no writes while done", capIdx, NWR);

    pulseStart();
    repeat (500) @(negedge clk);
    pulseStart();
    waitDone();
    chk(capIdx == 2 * NWR, "R9 replay write count", capIdx, 2 * NWR);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(negedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", capIdx, 2 * NWR);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule